// File: doc/BRIEF.md
# Copy-Only Processor Core

This core has 8-bit data and 16-bit addresses, and it runs a single kind of operation. Each instruction names a source address and a destination address. The core reads one byte from the source and writes the same byte, unchanged, to the destination. Nothing else is encoded in an instruction. Jumps, indirect access and every other kind of control come from copying bytes into a small set of registers that sit in the lowest sixteen addresses.

- **Program counter:** address 1 holds the low byte and address 3 the high byte. A write to the high byte is held in a staging register until the next write to the low byte.
- **Pointer:** addresses 5 and 7 hold its low and high bytes.
- **Pointer data port:** address 8 stands in for whatever location the pointer holds.

The core connects to one memory bus with combinational read data. While an access falls in the register window, the core raises a claim output so that external ROM stays off the bus. External ROM, RAM and peripherals sit outside the core.

The sequencer is a one-hot register with six named steps, always taken in this order:

| Step | Action |
|---|---|
| SRC_LO | fetch the source low byte |
| SRC_HI | fetch the source high byte |
| DST_LO | fetch the destination low byte |
| DST_HI | fetch the destination high byte |
| EXE_RD | read the source |
| EXE_WR | write the destination |

Each step has a single transition, to the next step in the list, and EXE_WR returns to SRC_LO.

Top module: `movcpu_core`

## Requirements
- R1: An instruction is four bytes fetched from consecutive addresses starting at the PC, in this order: source low, source high, destination low, destination high. The bus address of each fetch is the PC, and the PC advances by one after each fetched byte.
- R2: Every instruction takes exactly six cycles, SRC_LO, SRC_HI, DST_LO, DST_HI, EXE_RD, EXE_WR, so the source read is in cycle 5 and the destination write in cycle 6. EXE_WR always returns to SRC_LO.
- R3: The byte read in EXE_RD is the byte driven in EXE_WR. The source location keeps its value, so a second copy from the same source yields the same byte.
- R4: A write to address 0x0000 is discarded. The same applies to an unassigned address in 0x0000–0x000F (all except 1, 3, 5, 7 and 8). Reading these addresses returns 0x00, and no bus strobe is raised for them.
- R5: Reading address 0x0001 returns the low byte of the PC, which by EXE_RD already points at the next instruction. Writing 0x0001 sets the PC to {staged high byte, written byte}, and the next fetch starts there instead of at the incremented PC.
- R6: Reading address 0x0003 returns the PC high byte. Writing 0x0003 loads only the staging register, so execution continues with the next sequential instruction.
- R7: Addresses 0x0005 and 0x0007 are write-only and load the pointer low and high bytes. Reading either returns 0x00.
- R8: A read or write of address 0x0008 during EXE_RD or EXE_WR uses the 16-bit pointer as the bus address. If the pointer itself holds 0x0008, the access acts as unassigned.
- R9: A synchronous reset clears the PC, the staging register and the pointer to 0 and puts the sequencer in SRC_LO, so the first fetch is at address 0x0000.
- R10: The claim output is high exactly when the effective bus address is below 0x0010, and the read and write strobes are never high together with it. Fetches from this window read the internal values and are not redirected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Effective bus address |
| mem_rd | output | 1 | Read strobe for external memory |
| mem_wr | output | 1 | Write strobe for external memory |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Combinational read data |
| bus_claim | output | 1 | High while the access is in the register window, so external ROM must not drive the bus |

## Verification
After reset, the program runs four filler instructions from the register window and then starts at 0x0010, so instruction k of the program starts at cycle 24+6(k-1). Its source read falls in the fifth cycle of the instruction and its bus write in the sixth. Each expected write goes into a scoreboard together with the cycle in which it is due, and the monitor compares address, data and cycle at the falling edge. Any write that was not expected is a mismatch, which is how the bench catches a discarded write that leaks onto the bus or a skipped instruction that runs. Point checks on fetch addresses and the redirected read are made at the falling edge of their computed cycle.

// File: rtl/movcpu_pkg.sv
package movcpu_pkg;

    // One-hot instruction steps, taken in list order
    typedef enum logic [5:0] {
        ST_SRC_LO = 6'b000001,
        ST_SRC_HI = 6'b000010,
        ST_DST_LO = 6'b000100,
        ST_DST_HI = 6'b001000,
        ST_EXE_RD = 6'b010000,
        ST_EXE_WR = 6'b100000
    } step_e;

    // Register window decode (behavioural addresses)
    localparam int unsigned REG_SINK = 0;
    localparam int unsigned REG_PCL  = 1;
    localparam int unsigned REG_PCH  = 3;
    localparam int unsigned REG_PTRL = 5;
    localparam int unsigned REG_PTRH = 7;
    localparam int unsigned REG_PORT = 8;

endpackage

// File: rtl/movcpu_seq.sv
module movcpu_seq
    import movcpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output step_e step
);

    step_e step_nxt;

    always_ff @(posedge clk) begin
        if (rst) step <= ST_SRC_LO;
        else     step <= step_nxt;
    end

    always_comb begin
        unique case (step)
            ST_SRC_LO: step_nxt = ST_SRC_HI;
            ST_SRC_HI: step_nxt = ST_DST_LO;
            ST_DST_LO: step_nxt = ST_DST_HI;
            ST_DST_HI: step_nxt = ST_EXE_RD;
            ST_EXE_RD: step_nxt = ST_EXE_WR;
            ST_EXE_WR: step_nxt = ST_SRC_LO;
            default:   step_nxt = ST_SRC_LO;
        endcase
    end

    // R2
    step_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(step) == 1);

    // R2
    wrap_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        step == ST_EXE_WR |=> step == ST_SRC_LO);

    // R9
    reset_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> step == ST_SRC_LO);

endmodule

// File: rtl/movcpu_bus.sv
module movcpu_bus
    import movcpu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 16,
    parameter int LOW_WIN = 16
) (
    input  step_e              step,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [ADDR_W-1:0]  src,
    input  logic [ADDR_W-1:0]  dst,
    input  logic [ADDR_W-1:0]  ptr,
    input  logic [DATA_W-1:0]  data_q,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0]  eff_addr,
    output logic [DATA_W-1:0]  rd_byte,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               claim
);

    logic              fetch;
    logic              low;
    logic [ADDR_W-1:0] raw;
    logic [DATA_W-1:0] int_byte;

    always_comb begin
        fetch = !(step == ST_EXE_RD || step == ST_EXE_WR);
        if (fetch)                  raw = pc;
        else if (step == ST_EXE_RD) raw = src;
        else                        raw = dst;

        if (!fetch && raw == ADDR_W'(REG_PORT)) eff_addr = ptr;
        else                                     eff_addr = raw;

        low = eff_addr < ADDR_W'(LOW_WIN);

        if (eff_addr == ADDR_W'(REG_PCL))      int_byte = pc[DATA_W-1:0];
        else if (eff_addr == ADDR_W'(REG_PCH)) int_byte = pc[ADDR_W-1:DATA_W];
        else                                   int_byte = '0;

        rd_byte   = low ? int_byte : mem_rdata;
        mem_addr  = eff_addr;
        mem_rd    = !low && (step != ST_EXE_WR);
        mem_wr    = !low && (step == ST_EXE_WR);
        mem_wdata = data_q;
        claim     = low;
    end

endmodule

// File: rtl/movcpu_regs.sv
module movcpu_regs
    import movcpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  step_e              step,
    input  logic [ADDR_W-1:0]  eff_addr,
    input  logic [DATA_W-1:0]  rd_byte,
    output logic [ADDR_W-1:0]  pc,
    output logic [ADDR_W-1:0]  src,
    output logic [ADDR_W-1:0]  dst,
    output logic [ADDR_W-1:0]  ptr,
    output logic [DATA_W-1:0]  data_q
);

    logic [DATA_W-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            stage  <= '0;
            ptr    <= '0;
            src    <= '0;
            dst    <= '0;
            data_q <= '0;
        end else begin
            unique case (step)
                ST_SRC_LO: begin
                    src[DATA_W-1:0] <= rd_byte;
                    pc <= pc + ADDR_W'(1);
                end
                ST_SRC_HI: begin
                    src[ADDR_W-1:DATA_W] <= rd_byte;
                    pc <= pc + ADDR_W'(1);
                end
                ST_DST_LO: begin
                    dst[DATA_W-1:0] <= rd_byte;
                    pc <= pc + ADDR_W'(1);
                end
                ST_DST_HI: begin
                    dst[ADDR_W-1:DATA_W] <= rd_byte;
                    pc <= pc + ADDR_W'(1);
                end
                ST_EXE_RD: data_q <= rd_byte;
                ST_EXE_WR: begin
                    if (eff_addr == ADDR_W'(REG_PCL))  pc <= {stage, data_q};
                    if (eff_addr == ADDR_W'(REG_PCH))  stage <= data_q;
                    if (eff_addr == ADDR_W'(REG_PTRL)) ptr[DATA_W-1:0] <= data_q;
                    if (eff_addr == ADDR_W'(REG_PTRH)) ptr[ADDR_W-1:DATA_W] <= data_q;
                end
                default: ;
            endcase
        end
    end

    // R1
    pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step == ST_SRC_LO || step == ST_SRC_HI || step == ST_DST_LO || step == ST_DST_HI)
        |=> pc == $past(pc) + ADDR_W'(1));

    // R5
    pc_load_chk: assert property (@(posedge clk) disable iff (rst)
        (step == ST_EXE_WR && eff_addr == ADDR_W'(REG_PCL))
        |=> pc == {$past(stage), $past(data_q)});

    // R6
    pch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step == ST_EXE_WR && eff_addr == ADDR_W'(REG_PCH)) |=> $stable(pc));

    // R9
    reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc == '0);

endmodule

// File: rtl/movcpu_core.sv
module movcpu_core
    import movcpu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 16,
    parameter int LOW_WIN = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              bus_claim
);

    step_e             step;
    logic [ADDR_W-1:0] pc, src, dst, ptr, eff_addr;
    logic [DATA_W-1:0] data_q, rd_byte;

    movcpu_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .step (step)
    );

    movcpu_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .eff_addr (eff_addr),
        .rd_byte  (rd_byte),
        .pc       (pc),
        .src      (src),
        .dst      (dst),
        .ptr      (ptr),
        .data_q   (data_q)
    );

    movcpu_bus #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOW_WIN(LOW_WIN)) u_bus (
        .step      (step),
        .pc        (pc),
        .src       (src),
        .dst       (dst),
        .ptr       (ptr),
        .data_q    (data_q),
        .mem_rdata (mem_rdata),
        .eff_addr  (eff_addr),
        .rd_byte   (rd_byte),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .claim     (bus_claim)
    );

    // R10
    claim_excl_chk: assert property (@(posedge clk) disable iff (rst)
        bus_claim |-> !(mem_rd || mem_wr));

    // R4
    sink_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_addr == ADDR_W'(REG_SINK)) |-> !mem_wr);

endmodule

// File: tb/movcpu_core_test.sv
`timescale 1ns/1ps
module movcpu_core_test;

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  data;
        int          cyc;
        string       req;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, bus_claim;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  rom [2048];
    logic [7:0]  ram [2048];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;
    wr_item_t    exp_q[$];

    always #10 clk = ~clk;

    movcpu_core uut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .bus_claim (bus_claim)
    );

    assign mem_rdata = mem_addr[15] ? ram[mem_addr[10:0]] : rom[mem_addr[10:0]];

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
        if (!rst && mem_wr && mem_addr[15]) ram[mem_addr[10:0]] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic put_ins(input int at, input logic [15:0] s, input logic [15:0] d);
        rom[at]   = s[7:0];
        rom[at+1] = s[15:8];
        rom[at+2] = d[7:0];
        rom[at+3] = d[15:8];
    endtask

    task automatic expect_wr(input logic [15:0] a, input logic [7:0] d,
                             input int c, input string req);
        wr_item_t it;
        it.addr = a; it.data = d; it.cyc = c; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard on every bus write, checks claim each cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            // R10
            check(bus_claim == (mem_addr < 16), "R10", "claim vs address", bus_claim, mem_addr < 16);
            check(!(bus_claim && (mem_rd || mem_wr)), "R10", "strobe under claim",
                  {mem_rd, mem_wr}, 0);
            if (mem_wr) begin
                if (exp_q.size() == 0) begin
                    check(0, "R4", "unexpected write address", mem_addr, 0);
                end else begin
                    wr_item_t it;
                    it = exp_q.pop_front();
                    check(mem_addr == it.addr, it.req, "write address", mem_addr, it.addr);
                    check(mem_wdata == it.data, it.req, "write data", mem_wdata, it.data);
                    // R2
                    check(cyc == it.cyc, "R2", "write cycle", cyc, it.cyc);
                end
            end
        end
    end

    initial begin
        repeat (6000) @(posedge clk);
        check(0, "R2", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin
            rom[i] = 8'h00;
            ram[i] = 8'h00;
        end
        rom[11'h100] = 8'h5A; rom[11'h101] = 8'h20; rom[11'h102] = 8'h80;
        rom[11'h103] = 8'hC3; rom[11'h104] = 8'h02; rom[11'h105] = 8'h77;
        rom[11'h106] = 8'h00; rom[11'h107] = 8'hEE; rom[11'h108] = 8'h99;
        rom[11'h109] = 8'h0C;
        put_ins(16'h10, 16'h0100, 16'h8000); // I1 plain copy
        put_ins(16'h14, 16'h0101, 16'h0005); // I2 pointer low
        put_ins(16'h18, 16'h0102, 16'h0007); // I3 pointer high
        put_ins(16'h1C, 16'h0103, 16'h0008); // I4 write via pointer
        put_ins(16'h20, 16'h0008, 16'h8001); // I5 read via pointer
        put_ins(16'h24, 16'h0001, 16'h8002); // I6 read PC low
        put_ins(16'h28, 16'h0003, 16'h8003); // I7 read PC high
        put_ins(16'h2C, 16'h0005, 16'h8004); // I8 read pointer low
        put_ins(16'h30, 16'h0000, 16'h0000); // I9 sink
        put_ins(16'h34, 16'h0104, 16'h0003); // I10 stage high byte
        put_ins(16'h38, 16'h0105, 16'h8005); // I11 sequential
        put_ins(16'h3C, 16'h0106, 16'h0001); // I12 jump to 0x0200
        put_ins(16'h40, 16'h0107, 16'h8006); // I13 must be skipped
        put_ins(16'h200, 16'h0108, 16'h8007); // I14
        put_ins(16'h204, 16'h8007, 16'h8008); // I15
        put_ins(16'h208, 16'h8007, 16'h8009); // I16 source unchanged
        put_ins(16'h20C, 16'h0109, 16'h0001); // I17 loop on itself

        expect_wr(16'h8000, 8'h5A, 29,  "R3");
        expect_wr(16'h8020, 8'hC3, 47,  "R8");
        expect_wr(16'h8001, 8'hC3, 53,  "R8");
        expect_wr(16'h8002, 8'h28, 59,  "R5");
        expect_wr(16'h8003, 8'h00, 65,  "R6");
        expect_wr(16'h8004, 8'h00, 71,  "R7");
        expect_wr(16'h8005, 8'h77, 89,  "R6");
        expect_wr(16'h8007, 8'h99, 101, "R5");
        expect_wr(16'h8008, 8'h99, 107, "R3");
        expect_wr(16'h8009, 8'h99, 113, "R3");

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9
        check(mem_addr == 16'h0000, "R9", "first fetch address", mem_addr, 0);
        check(bus_claim == 1'b1 && !mem_rd && !mem_wr, "R9", "reset bus state",
              {bus_claim, mem_rd, mem_wr}, 3'b100);

        wait_cyc(24);
        // R1
        check(mem_addr == 16'h0010 && mem_rd, "R1", "program fetch byte 0", mem_addr, 16'h0010);
        wait_cyc(25);
        check(mem_addr == 16'h0011 && mem_rd, "R1", "program fetch byte 1", mem_addr, 16'h0011);
        wait_cyc(52);
        // R8
        check(mem_addr == 16'h8020 && mem_rd, "R8", "redirected read", mem_addr, 16'h8020);
        wait_cyc(77);
        // R4
        check(!mem_wr && bus_claim, "R4", "sink write quiet", mem_wr, 0);
        wait_cyc(84);
        // R6
        check(mem_addr == 16'h0038, "R6", "sequential after stage", mem_addr, 16'h0038);
        wait_cyc(96);
        // R5
        check(mem_addr == 16'h0200 && mem_rd, "R5", "jump target fetch", mem_addr, 16'h0200);
        wait_cyc(300);
        // R3
        check(exp_q.size() == 0, "R3", "writes outstanding", exp_q.size(), 0);
        check(ram[11'h007] == 8'h99, "R3", "source kept", ram[11'h007], 8'h99);
        finish_run();
    end

endmodule